// File: doc/BRIEF.md
# Paired-Byte Word Write Bus Controller

This block turns byte-wide write requests into write cycles for a 16-bit memory that sits on a multiplexed address/data bus. Each request carries a 21-bit byte pointer and one data byte. The block cannot write a single byte to the word memory. A request to an even byte address therefore only stores its byte in an internal holding register. A request to the odd byte address of the same word then writes the full word. The new byte goes on the upper half of the bus, the stored byte goes on the lower half, and both byte selects are active. Software must issue writes as even/odd pairs on one word boundary.

Every accepted request runs one bus cycle of four clocks. In the first clock the address-latch strobe is high and the word address is on the bus. In the second clock the strobe is low and the address is held. The third clock is the data phase, and the write strobe is asserted there if the cycle writes memory. In the fourth clock the strobe is released and the data is held. The word address is pointer bits [20:1]. Its low 16 bits go out multiplexed on the bus and its top 4 bits go out on a separate port. While a cycle runs the block reports busy and ignores new requests. A done pulse marks the last clock of the cycle.

Top module: `word_pair_writer`

## Requirements
- R1: After reset and between cycles the block is idle. In that state busy, done, bus enable and the address-latch strobe are 0. The bus and upper address are 0x0000 and 0x0. Both write strobes and both byte selects are high (active-low, so inactive). The byte-LSB output is 0.
- R2: A request seen at a clock edge while idle starts a cycle. Busy is high for exactly the next four clocks. The address-latch strobe is high only in the first of those clocks.
- R3: In phases 1 and 2 the bus enable is 1, the bus carries pointer bits [16:1] and the upper address output carries pointer bits [20:17]. The upper address output keeps that value for all four phases.
- R4: In an even-pointer cycle (pointer bit 0 = 0), phases 3 and 4 have the bus enable at 0 and the bus driven to 0x0000. The high write strobe and both byte selects stay inactive. The data byte is stored in the holding register.
- R5: In an odd-pointer cycle, phases 3 and 4 have the bus enable at 1. The bus carries the request byte in bits [15:8] and the holding register in bits [7:0].
- R6: The active-low high-byte write strobe is low only in phase 3 of odd-pointer cycles. The active-low low-byte write strobe is never asserted.
- R7: Both active-low byte selects are low in phases 3 and 4 of odd-pointer cycles, and high otherwise.
- R8: The byte-LSB output equals pointer bit 0 in all four phases of a cycle.
- R9: Requests seen while busy are ignored. They change neither the running cycle nor the holding register, and they start no later cycle.
- R10: Done is high only in phase 4 of each cycle.
- R11: Reset clears the holding register to 0x00. An odd-pointer write with no preceding even write still writes memory, using the current holding register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Write request strobe |
| ptr_i | input | 21 | Byte pointer of the request |
| data_i | input | 8 | Data byte of the request |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Last clock of a cycle |
| mux_bus_o | output | 16 | Multiplexed address/data bus value |
| bus_oe_o | output | 1 | Drive enable for the multiplexed bus |
| addr_top_o | output | 4 | Upper word-address bits |
| addr_latch_o | output | 1 | Address-latch strobe, active high |
| hi_wr_n_o | output | 1 | High-byte write strobe, active low |
| lo_wr_n_o | output | 1 | Low-byte write strobe, active low |
| upper_sel_n_o | output | 1 | Upper byte select, active low |
| lower_sel_n_o | output | 1 | Lower byte select, active low |
| byte_lsb_o | output | 1 | Pointer bit 0 during a cycle |

## Verification
The bench targets the following corner cases:
- **First odd write after reset.** A design that does not clear the holding register on reset would put an unknown or stale value on the low byte.
- **Even write followed by its odd partner.** A design that loads the holding register at the wrong moment, or also on odd writes, would present the wrong low byte.
- **Requests held high through a whole cycle.** A design that leaks these would corrupt the address or data mid-cycle, or chain a second cycle.
- **Even cycles.** A design that pulses the write strobe or enables the bus during an even data phase would write half a word.

Randomized pointers exercise the address split, including the top address bits and the byte-LSB output.

// File: rtl/word_pair_writer.sv
module word_pair_writer #(
  parameter int PTR_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [7:0]       data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [15:0]      mux_bus_o,
  output logic             bus_oe_o,
  output logic [PTR_W-18:0] addr_top_o,
  output logic             addr_latch_o,
  output logic             hi_wr_n_o,
  output logic             lo_wr_n_o,
  output logic             upper_sel_n_o,
  output logic             lower_sel_n_o,
  output logic             byte_lsb_o
);
  localparam int WA_W = PTR_W - 1;

  typedef enum logic [2:0] {S_IDLE, S_ALE, S_ADR, S_DAT, S_HLD} phase_t;

  phase_t           ph;
  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       byte_q;
  logic [7:0]       hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= S_IDLE;
      ptr_q  <= '0;
      byte_q <= '0;
      hold_q <= '0;
    end else begin
      case (ph)
        S_IDLE: if (req_i) begin
          ptr_q  <= ptr_i;
          byte_q <= data_i;
          if (!ptr_i[0]) hold_q <= data_i;
          ph <= S_ALE;
        end
        S_ALE:   ph <= S_ADR;
        S_ADR:   ph <= S_DAT;
        S_DAT:   ph <= S_HLD;
        default: ph <= S_IDLE;
      endcase
    end
  end

  wire [WA_W-1:0] waddr   = ptr_q[PTR_W-1:1];
  wire            odd     = ptr_q[0];
  wire            addr_ph = (ph == S_ALE) || (ph == S_ADR);
  wire            data_ph = (ph == S_DAT) || (ph == S_HLD);
  wire            wr_word = data_ph && odd;

  assign busy_o        = (ph != S_IDLE);
  assign done_o        = (ph == S_HLD);
  assign addr_latch_o  = (ph == S_ALE);
  assign bus_oe_o      = addr_ph || wr_word;
  assign mux_bus_o     = addr_ph ? waddr[15:0] : (wr_word ? {byte_q, hold_q} : 16'h0000);
  assign addr_top_o    = busy_o ? waddr[WA_W-1:16] : '0;
  assign byte_lsb_o    = busy_o && odd;
  assign hi_wr_n_o     = !((ph == S_DAT) && odd);
  assign lo_wr_n_o     = 1'b1;
  assign upper_sel_n_o = !wr_word;
  assign lower_sel_n_o = !wr_word;

  AST_STROBE_ODD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr_n_o |-> bus_oe_o && !upper_sel_n_o && !lower_sel_n_o && byte_lsb_o); // R6
  AST_LATCH_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch_o |=> !addr_latch_o && busy_o && $stable(mux_bus_o)); // R2
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o); // R10
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr_n_o |=> hi_wr_n_o && $stable(mux_bus_o) && done_o); // R5
  AST_TOP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o |=> $stable(addr_top_o) && $stable(byte_lsb_o)); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done_o && req_i |=> busy_o && !addr_latch_o); // R9
endmodule

// File: tb/word_pair_writer_tb.sv
`timescale 1ns/1ps
module word_pair_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [20:0] ptr_i = '0;
  logic [7:0]  data_i = '0;
  logic        busy_o, done_o, bus_oe_o, addr_latch_o;
  logic        hi_wr_n_o, lo_wr_n_o, upper_sel_n_o, lower_sel_n_o, byte_lsb_o;
  logic [15:0] mux_bus_o;
  logic [3:0]  addr_top_o;

  int vectors = 0;
  int errors  = 0;
  logic [7:0] lat_m = 8'h00;

  always #2 clk = ~clk;

  word_pair_writer u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ptr_i(ptr_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .mux_bus_o(mux_bus_o), .bus_oe_o(bus_oe_o),
    .addr_top_o(addr_top_o), .addr_latch_o(addr_latch_o), .hi_wr_n_o(hi_wr_n_o),
    .lo_wr_n_o(lo_wr_n_o), .upper_sel_n_o(upper_sel_n_o), .lower_sel_n_o(lower_sel_n_o),
    .byte_lsb_o(byte_lsb_o)
  );

  // {busy, done, oe, bus[15:0], top[3:0], ale, hi_n, lo_n, ub_n, lb_n, lsb}
  function automatic logic [28:0] exp_out(int ph, logic [20:0] p, logic [7:0] d, logic [7:0] lat);
    logic odd = p[0];
    case (ph)
      1: return {1'b1, 1'b0, 1'b1, p[16:1], p[20:17], 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, odd};
      2: return {1'b1, 1'b0, 1'b1, p[16:1], p[20:17], 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, odd};
      3: return odd ? {1'b1, 1'b0, 1'b1, d, lat, p[20:17], 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
                    : {1'b1, 1'b0, 1'b0, 16'h0000, p[20:17], 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
      4: return odd ? {1'b1, 1'b1, 1'b1, d, lat, p[20:17], 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}
                    : {1'b1, 1'b1, 1'b0, 16'h0000, p[20:17], 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
      default: return {1'b0, 1'b0, 1'b0, 16'h0000, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
    endcase
  endfunction

  function automatic string ph_req(int ph, logic odd);
    case (ph)
      1: return "R2 R3 R8";
      2: return "R3 R8";
      3: return odd ? "R5 R6 R7 R11" : "R4 R6 R7";
      4: return odd ? "R10 R5 R7" : "R10 R4";
      default: return "R1 R9";
    endcase
  endfunction

  task automatic check(int ph, logic [20:0] p, logic [7:0] d, logic [7:0] lat);
    logic [28:0] act = {busy_o, done_o, bus_oe_o, mux_bus_o, addr_top_o, addr_latch_o,
                        hi_wr_n_o, lo_wr_n_o, upper_sel_n_o, lower_sel_n_o, byte_lsb_o};
    logic [28:0] exp = exp_out(ph, p, d, lat);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s phase %0d: actual %h expected %h", ph_req(ph, p[0]), ph, act, exp);
    end
  endtask

  task automatic do_write(logic [20:0] p, logic [7:0] d, bit junk);
    logic [7:0] lat = lat_m;
    @(negedge clk);
    req_i = 1'b1; ptr_i = p; data_i = d;
    for (int ph = 1; ph <= 4; ph++) begin
      @(negedge clk);
      if (junk) begin   // R9: requests while busy must be ignored
        req_i = 1'b1; ptr_i = 21'($urandom); data_i = 8'($urandom);
      end else begin
        req_i = 1'b0;
      end
      check(ph, p, d, lat);
    end
    if (!p[0]) lat_m = d;
    @(negedge clk);
    req_i = 1'b0;
    check(0, '0, '0, '0);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    check(0, '0, '0, '0);                 // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(0, '0, '0, '0);                 // R1 idle with no request
    do_write(21'h1ABCD5, 8'h3C, 1'b0);    // R11 odd write right after reset uses 0x00
    do_write(21'h000010, 8'hA5, 1'b0);    // R4 even load
    do_write(21'h000011, 8'h5A, 1'b0);    // R5 matching odd
    do_write(21'h1FFFFE, 8'hFF, 1'b1);    // R9 junk during even
    do_write(21'h1FFFFF, 8'h00, 1'b1);    // R9 junk during odd
    do_write(21'h000001, 8'h77, 1'b0);    // R11 unpaired odd reuses latch
    for (int i = 0; i < 300; i++) begin
      logic [20:0] p = 21'($urandom);
      logic [7:0]  d = 8'($urandom);
      bit jk = ($urandom % 4) == 0;
      if (($urandom % 3) != 0) begin
        p[0] = 1'b0;
        do_write(p, d, jk);
        p[0] = 1'b1;
        do_write(p, 8'($urandom), jk);
      end else begin
        do_write(p, d, jk);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule